// File: doc/BRIEF.md
# Time Base and Watchdog on a Shared Prescaler

This block produces a periodic time-base tick and a watchdog interrupt from one system clock. A single free-running divide-by-256 prescaler feeds two independent stage counters. The time-base stage gives a one-clock tick each time it wraps. The watchdog stage raises an interrupt after a set number of prescaler carries unless software clears it first.

Software drives the block with one command per cycle on `cmd_valid`/`cmd_op`. There are three independent groups of commands: the time base (on, off, clear), the watchdog (on, off, clear) and the interrupt line (unmask, mask). The interrupt output is active low. Once a timeout pulls it low, it stays low until the watchdog is cleared or the interrupt is masked.

The design is built from state machines. The time base has states `TB_IDLE` and `TB_RUN`, moved by the on/off commands. The watchdog has states `WD_IDLE` and `WD_RUN`, moved the same way. The interrupt line has three states: `IRQ_MASKED`, `IRQ_ARMED` and `IRQ_LOW`. Its transitions are:
- MASKED→ARMED on unmask.
- ARMED→LOW on timeout.
- LOW→ARMED on watchdog clear.
- any state→MASKED on mask.

Top module: `shared_tick_watchdog`

## Requirements
- R1: After reset, both stages and the interrupt are disabled and every counter is zero: `tick` is 0, `irq_n` is 1, and with no commands neither output ever changes.
- R2: Command codes on `cmd_op`, taken only while `cmd_valid` is 1: 0 time base off, 1 time base on, 2 time base clear, 3 watchdog off, 4 watchdog on, 5 watchdog clear, 6 interrupt unmask, 7 interrupt mask.
- R3: The prescaler counts every clock while either stage is enabled. It returns to zero when both are disabled. No clear command resets it.
- R4: `tick` is a one-clock pulse. With defaults, the first pulse comes 4096 clock edges after the time-base-on edge, and further pulses follow every 4096 clocks (256 × 2^TB_BITS).
- R5: Time-base clear zeroes only the time-base stage. Time-base off stops the ticks. Neither affects the watchdog timing or `irq_n`.
- R6: The watchdog times out on its WD_LEN-th prescaler carry (4096 clocks after enable with defaults). Watchdog off holds the stage count, and a later enable resumes from that count.
- R7: Watchdog commands and interrupt commands do not change the time-base tick timing.
- R8: A timeout while the interrupt is unmasked drives `irq_n` low at the timeout edge. It stays low through further time passing and time-base commands.
- R9: Watchdog clear or interrupt mask drives `irq_n` high on the edge that takes the command.
- R10: A timeout while the interrupt is masked is lost: `irq_n` stays high, and a later unmask does not pull it low until a new timeout.
- R11: A clear, off or mask command on the same edge as a stage's terminal carry wins: no tick or timeout results. With defaults, the next event comes a full 4096 clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | Command code (see R2) |
| tick | output | 1 | Time-base pulse |
| irq_n | output | 1 | Active-low watchdog interrupt |

## Verification
Two kinds of events can fall on the same clock edge: a software command and a stage's terminal prescaler carry. The bench provokes this in three ways, each issued on exactly the edge where the timeout or tick is due:
- a watchdog clear;
- an interrupt mask;
- a time-base clear.

The bench judges each case by checking that the output stays quiet on that edge, and that the next event arrives one full stage period later, counted from the command.

// File: rtl/stw_pkg.sv
package stw_pkg;

    typedef enum logic [2:0] {
        OP_TB_OFF  = 3'd0,
        OP_TB_ON   = 3'd1,
        OP_TB_CLR  = 3'd2,
        OP_WD_OFF  = 3'd3,
        OP_WD_ON   = 3'd4,
        OP_WD_CLR  = 3'd5,
        OP_IRQ_ON  = 3'd6,
        OP_IRQ_OFF = 3'd7
    } cmd_op_e;

    typedef struct packed {
        logic tb_off;
        logic tb_on;
        logic tb_clr;
        logic wd_off;
        logic wd_on;
        logic wd_clr;
        logic irq_on;
        logic irq_off;
    } cmd_pulse_t;

    typedef enum logic {TB_IDLE, TB_RUN} tb_state_e;
    typedef enum logic {WD_IDLE, WD_RUN} wd_state_e;
    typedef enum logic [1:0] {IRQ_MASKED, IRQ_ARMED, IRQ_LOW} irq_state_e;

endpackage

// File: rtl/stw_cmd_decode.sv
module stw_cmd_decode
    import stw_pkg::*;
(
    input  logic       valid,
    input  logic [2:0] op,
    output cmd_pulse_t pulse
);
    always_comb begin
        pulse = '0;
        if (valid) begin
            unique case (cmd_op_e'(op))
                OP_TB_OFF:  pulse.tb_off  = 1'b1;
                OP_TB_ON:   pulse.tb_on   = 1'b1;
                OP_TB_CLR:  pulse.tb_clr  = 1'b1;
                OP_WD_OFF:  pulse.wd_off  = 1'b1;
                OP_WD_ON:   pulse.wd_on   = 1'b1;
                OP_WD_CLR:  pulse.wd_clr  = 1'b1;
                OP_IRQ_ON:  pulse.irq_on  = 1'b1;
                OP_IRQ_OFF: pulse.irq_off = 1'b1;
                default:    pulse = '0;
            endcase
        end
    end
endmodule

// File: rtl/stw_prescaler.sv
module stw_prescaler #(
    parameter int PRE_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    output logic [PRE_BITS-1:0] count,
    output logic                carry
);
    localparam logic [PRE_BITS-1:0] TOP = {PRE_BITS{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (!run) begin
            count <= '0;
        end else begin
            count <= count + 1'b1;
        end
    end

    always_comb begin
        carry = run && (count == TOP);
    end
endmodule

// File: rtl/stw_timebase.sv
module stw_timebase
    import stw_pkg::*;
#(
    parameter int TB_BITS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic dis,
    input  logic clr,
    input  logic carry,
    output logic running,
    output logic tick
);
    localparam logic [TB_BITS-1:0] LAST = {TB_BITS{1'b1}};

    tb_state_e           state_q, state_d;
    logic [TB_BITS-1:0]  stage_q;
    logic                active;
    logic                wrap;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TB_IDLE: if (en)  state_d = TB_RUN;
            TB_RUN:  if (dis) state_d = TB_IDLE;
            default: state_d = TB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TB_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        active = (state_q == TB_RUN) && !dis;
        wrap   = active && carry && !clr && (stage_q == LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else if (clr) begin
            stage_q <= '0;
        end else if (active && carry) begin
            stage_q <= stage_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tick <= 1'b0;
        else        tick <= wrap;
    end

    always_comb begin
        running = (state_q == TB_RUN);
    end
endmodule

// File: rtl/stw_watchdog.sv
module stw_watchdog
    import stw_pkg::*;
#(
    parameter int WD_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic dis,
    input  logic clr,
    input  logic carry,
    output logic running,
    output logic timeout
);
    localparam int              WD_W = (WD_LEN > 2) ? $clog2(WD_LEN) : 1;
    localparam logic [WD_W-1:0] LAST = WD_W'(WD_LEN - 1);

    wd_state_e       state_q, state_d;
    logic [WD_W-1:0] cnt_q;
    logic            active;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_IDLE: if (en)  state_d = WD_RUN;
            WD_RUN:  if (dis) state_d = WD_IDLE;
            default: state_d = WD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        active = (state_q == WD_RUN) && !dis;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (active && carry) begin
            if (cnt_q == LAST) cnt_q <= '0;
            else               cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        timeout = active && carry && !clr && (cnt_q == LAST);
        running = (state_q == WD_RUN);
    end
endmodule

// File: rtl/stw_irq_latch.sv
module stw_irq_latch
    import stw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic disarm,
    input  logic release_req,
    input  logic timeout,
    output logic irq_n
);
    irq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (disarm) begin
            state_d = IRQ_MASKED;
        end else begin
            unique case (state_q)
                IRQ_MASKED: if (arm)         state_d = IRQ_ARMED;
                IRQ_ARMED:  if (timeout)     state_d = IRQ_LOW;
                IRQ_LOW:    if (release_req) state_d = IRQ_ARMED;
                default:                     state_d = IRQ_MASKED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_MASKED;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_n = (state_q != IRQ_LOW);
    end
endmodule

// File: rtl/shared_tick_watchdog.sv
module shared_tick_watchdog
    import stw_pkg::*;
#(
    parameter int PRE_BITS = 8,
    parameter int TB_BITS  = 4,
    parameter int WD_LEN   = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_op,
    output logic       tick,
    output logic       irq_n
);
    cmd_pulse_t          cmd;
    logic [PRE_BITS-1:0] pre_cnt;
    logic                pre_carry;
    logic                tb_running;
    logic                wd_running;
    logic                any_run;
    logic                wd_timeout;

    stw_cmd_decode u_dec (
        .valid (cmd_valid),
        .op    (cmd_op),
        .pulse (cmd)
    );

    always_comb begin
        any_run = tb_running || wd_running;
    end

    stw_prescaler #(.PRE_BITS(PRE_BITS)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (any_run),
        .count (pre_cnt),
        .carry (pre_carry)
    );

    stw_timebase #(.TB_BITS(TB_BITS)) u_tb (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (cmd.tb_on),
        .dis     (cmd.tb_off),
        .clr     (cmd.tb_clr),
        .carry   (pre_carry),
        .running (tb_running),
        .tick    (tick)
    );

    stw_watchdog #(.WD_LEN(WD_LEN)) u_wd (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (cmd.wd_on),
        .dis     (cmd.wd_off),
        .clr     (cmd.wd_clr),
        .carry   (pre_carry),
        .running (wd_running),
        .timeout (wd_timeout)
    );

    stw_irq_latch u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm         (cmd.irq_on),
        .disarm      (cmd.irq_off),
        .release_req (cmd.wd_clr),
        .timeout     (wd_timeout),
        .irq_n       (irq_n)
    );
endmodule

// File: rtl/stw_checker.sv
module stw_checker
    import stw_pkg::*;
#(
    parameter int PRE_BITS = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cmd_valid,
    input logic [2:0]          cmd_op,
    input logic                tick,
    input logic                irq_n,
    input logic [PRE_BITS-1:0] pre_cnt,
    input logic                pre_carry,
    input logic                any_run,
    input logic                wd_timeout
);
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq_n && !tick));

    p_idle_prescaler_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !any_run |=> (pre_cnt == '0));

    p_tick_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    p_tick_after_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> $past(pre_carry));

    p_timeout_on_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wd_timeout |-> pre_carry);

    p_irq_fall_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> $past(wd_timeout));

    p_clear_releases_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_WD_CLR) |=> irq_n);

    p_mask_releases_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_IRQ_OFF) |=> irq_n);
endmodule

bind shared_tick_watchdog stw_checker #(.PRE_BITS(PRE_BITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .tick       (tick),
    .irq_n      (irq_n),
    .pre_cnt    (pre_cnt),
    .pre_carry  (pre_carry),
    .any_run    (any_run),
    .wd_timeout (wd_timeout)
);

// File: tb/test_shared_tick_watchdog.sv
`timescale 1ns/1ps
module test_shared_tick_watchdog;
    localparam logic [2:0] TB_OFF = 3'd0, TB_ON = 3'd1, TB_CLR = 3'd2;
    localparam logic [2:0] WD_OFF = 3'd3, WD_ON = 3'd4, WD_CLR = 3'd5;
    localparam logic [2:0] IQ_ON = 3'd6, IQ_OFF = 3'd7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic       tick;
    logic       irq_n;
    int         cyc = 0;
    int         checks = 0;
    int         errors = 0;
    bit         finished = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    shared_tick_watchdog i_shared_tick_watchdog (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .tick(tick), .irq_n(irq_n)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic chk_int(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic goto(input int t);
        while (cyc < t) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic issue(input logic [2:0] op, output int at);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        @(posedge clk);
        #1;
        at = cyc;
        cmd_valid = 1'b0;
    endtask

    task automatic watch(input int t_end, output int ticks, output int lows);
        ticks = 0;
        lows  = 0;
        while (cyc < t_end) begin
            @(posedge clk);
            #1;
            if (tick === 1'b1) ticks++;
            if (irq_n === 1'b0) lows++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cmd_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        int tk, lw;
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1", "tick in reset", tick, 1'b0);
        chk("R1", "irq_n in reset", irq_n, 1'b1);
        do_reset();
        watch(cyc + 5000, tk, lw);
        chk_int("R1", "ticks with no commands", tk, 0);
        chk_int("R1", "irq low cycles with no commands", lw, 0);
    endtask

    task automatic t_timebase();
        int w, a, tk, lw;
        do_reset();
        issue(TB_ON, w);
        issue(IQ_ON, a);
        goto(w + 2000);
        issue(WD_CLR, a);
        issue(IQ_OFF, a);
        goto(w + 4095);
        chk("R4", "tick before first period", tick, 1'b0);
        goto(w + 4096);
        chk("R4", "first tick at 4096", tick, 1'b1);
        goto(w + 4097);
        chk("R4", "tick one cycle wide", tick, 1'b0);
        goto(w + 8191);
        chk("R7", "no early second tick", tick, 1'b0);
        goto(w + 8192);
        chk("R7", "second tick unaffected by watchdog/irq commands", tick, 1'b1);
        watch(w + 9000, tk, lw);
        chk_int("R2", "irq never low with watchdog off", lw, 0);
    endtask

    task automatic t_tb_clear();
        int w, a, tk, lw;
        do_reset();
        issue(IQ_ON, a);
        issue(WD_ON, w);
        issue(TB_ON, a);
        goto(w + 999);
        issue(TB_CLR, a);
        watch(w + 4863, tk, lw);
        chk_int("R5", "no tick before cleared period ends", tk, 0);
        chk("R5", "watchdog timed out despite timer clear", irq_n, 1'b0);
        goto(w + 4864);
        chk("R5", "tick after clear (prescaler kept phase)", tick, 1'b1);
        goto(w + 4999);
        issue(TB_OFF, a);
        watch(w + 9500, tk, lw);
        chk_int("R5", "no tick after timer off", tk, 0);
        chk("R8", "irq still low after timer commands", irq_n, 1'b0);
    endtask

    task automatic t_wd_timeout();
        int w, a;
        do_reset();
        issue(IQ_ON, a);
        issue(WD_ON, w);
        goto(w + 4095);
        chk("R6", "irq high before timeout", irq_n, 1'b1);
        goto(w + 4096);
        chk("R8", "irq low at timeout", irq_n, 1'b0);
        goto(w + 6999);
        chk("R8", "irq held low", irq_n, 1'b0);
        issue(WD_CLR, a);
        chk("R9", "watchdog clear releases irq", irq_n, 1'b1);
        goto(w + 11007);
        chk("R6", "no early timeout after clear", irq_n, 1'b1);
        goto(w + 11008);
        chk("R6", "timeout 16 carries after clear", irq_n, 1'b0);
        goto(w + 11499);
        issue(IQ_OFF, a);
        chk("R9", "mask releases irq", irq_n, 1'b1);
        issue(IQ_ON, a);
        goto(a + 100);
        chk("R10", "unmask does not recall old timeout", irq_n, 1'b1);
    endtask

    task automatic t_wd_hold();
        int w, k, a, tk, lw;
        do_reset();
        issue(IQ_ON, a);
        issue(WD_ON, w);
        goto(w + 1999);
        issue(WD_OFF, a);
        watch(w + 5999, tk, lw);
        chk_int("R6", "no timeout while watchdog off", lw, 0);
        issue(WD_ON, k);
        goto(k + 2303);
        chk("R6", "held count: not yet timed out", irq_n, 1'b1);
        goto(k + 2304);
        chk("R3", "held count resumes on restarted prescaler", irq_n, 1'b0);
    endtask

    task automatic t_irq_masked();
        int w, a, tk, lw;
        do_reset();
        issue(WD_ON, w);
        watch(w + 4500, tk, lw);
        chk_int("R10", "masked timeout leaves irq high", lw, 0);
        issue(IQ_ON, a);
        goto(w + 8191);
        chk("R10", "unmask alone keeps irq high", irq_n, 1'b1);
        goto(w + 8192);
        chk("R10", "next timeout after unmask pulls low", irq_n, 1'b0);
    endtask

    task automatic t_collide();
        int w, a;
        do_reset();
        issue(IQ_ON, a);
        issue(WD_ON, w);
        goto(w + 4095);
        issue(WD_CLR, a);
        chk("R11", "clear on terminal edge suppresses timeout", irq_n, 1'b1);
        goto(w + 4097);
        chk("R11", "still high after collision", irq_n, 1'b1);
        goto(w + 8191);
        chk("R11", "no timeout before full period", irq_n, 1'b1);
        goto(w + 8192);
        chk("R11", "timeout a full period after clear", irq_n, 1'b0);

        do_reset();
        issue(IQ_ON, a);
        issue(WD_ON, w);
        goto(w + 4095);
        issue(IQ_OFF, a);
        goto(w + 4200);
        chk("R11", "mask on terminal edge wins", irq_n, 1'b1);

        do_reset();
        issue(TB_ON, w);
        goto(w + 4095);
        issue(TB_CLR, a);
        chk("R11", "timer clear on terminal edge suppresses tick", tick, 1'b0);
        goto(w + 8191);
        chk("R11", "no tick before full period", tick, 1'b0);
        goto(w + 8192);
        chk("R11", "tick a full period after clear", tick, 1'b1);
    endtask

    initial begin
        t_reset();
        t_timebase();
        t_tb_clear();
        t_wd_timeout();
        t_wd_hold();
        t_irq_masked();
        t_collide();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired at cycle %0d actual=running expected=done", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule